// File: doc/BRIEF.md
# Packet Buffer Allocation Unit

This unit keeps track of which 256-byte pages of a controller's packet memory are in use. Software drives it through an 8-bit command word whose top three bits select an operation. It hands out transmit buffers as 6-bit packet numbers. Each packet number is the index of the first page of a contiguous run of pages. When an allocation cannot be met, the unit reports a failure, holds the request, and completes it on its own once enough pages have been released. It then signals that completion with a one-cycle event.

The unit also holds three queues of packet numbers. The transmit queue is filled by software and drained by the MAC. The transmit-completion queue is filled by the MAC when a frame has gone out. The receive queue is filled by the MAC and drained by software commands. A status word shows the head and the empty state of the receive and completion queues. The transmit queue head is brought out directly to the MAC. While a command is executing, a busy flag is raised, and command writes made while it is high are dropped.

Top module: `pbuf_alloc_unit`

## Requirements
- R1: After reset, busy is 0, alloc_result is 0, the transmit queue is empty, queue_status reads 16'h8080, q_overflow is 0 and every page is free.
- R2: Opcode 1 (cmd_word[7:5]) requests cmd_word[4:0]+1 contiguous pages. The unit takes the lowest-indexed free run that fits within 64 pages. alloc_result then holds 0 in bits 15:6 and the run's first page index in bits 5:0.
- R3: When no run fits, alloc_result reads 16'h8000 and the request stays pending. In the first cycle after the command in which the request fits, it is granted at the lowest fitting run, alloc_result takes the new packet number, and alloc_done pulses for exactly one cycle.
- R4: busy rises in the cycle after an accepted write. For every opcode other than 2, it falls one cycle later. A cmd_wr while busy is 1 has no effect.
- R5: Opcode 2 empties all three queues, clears q_overflow, drops any pending allocation, sets alloc_result to 0 and frees all pages. busy stays high for 9 cycles in total.
- R6: Opcode 6 appends sel_pkt to the transmit queue. tx_head and tx_empty show the oldest entry, and tx_pop removes it.
- R7: queue_status holds the following fields. Bit 15 is the receive queue empty flag. Bits 13:8 are the receive head. Bit 7 is the completion queue empty flag. Bits 5:0 are the completion head. Bits 14 and 6 are 0, and a head field reads 0 while its queue is empty.
- R8: Opcode 3 removes the receive head and leaves its pages in use. Opcode 4 removes the receive head and frees the pages that were allocated to it.
- R9: Opcode 5 frees the pages allocated to packet sel_pkt. If sel_pkt equals the head of a non-empty completion queue, that entry is also removed.
- R10: Opcode 7 empties the transmit and completion queues and leaves the receive queue unchanged.
- R11: Each queue holds 32 entries. A push into a full queue is dropped and sets a sticky flag: q_overflow bit 0 for transmit, bit 1 for completion, bit 2 for receive. Only opcode 2 or reset clears these flags.
- R12: A push and a removal on the same queue in the same cycle both take effect. A removal on an empty queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 8 | Opcode in bits 7:5, page count minus one in bits 4:0 |
| sel_pkt | input | 6 | Selected packet number for opcodes 5 and 6 |
| busy | output | 1 | Command in progress |
| alloc_result | output | 16 | Failure flag in bit 15, packet number in bits 5:0 |
| alloc_done | output | 1 | One-cycle pulse when a deferred allocation is granted |
| queue_status | output | 16 | Receive and completion queue empty flags and heads |
| tx_head | output | 6 | Oldest transmit queue entry (0 when empty) |
| tx_empty | output | 1 | Transmit queue empty |
| tx_pop | input | 1 | MAC removes the transmit head |
| txdone_push | input | 1 | MAC appends to the completion queue |
| txdone_pkt | input | 6 | Packet number to append to the completion queue |
| rx_push | input | 1 | MAC appends to the receive queue |
| rx_pkt | input | 6 | Packet number to append to the receive queue |
| q_overflow | output | 3 | Sticky overflow flags: bit 0 tx, 1 completion, 2 rx |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a software removal from the receive queue and a MAC push into the same queue. The bench provokes it by holding rx_push high during the exact cycle in which a removal command executes. It does this once with one entry already queued and once with the queue empty, and judges the outcome from the receive head and empty bit afterwards. The second pair is a page release and a pending deferred allocation. The bench fills the memory, makes an allocation fail, and then releases a run. It expects the grant, the new packet number and the single alloc_done pulse exactly one cycle after the release completes.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;

    localparam int PKT_W     = 6;
    localparam int NPAGES    = 1 << PKT_W;
    localparam int SIZE_W    = 5;
    localparam int QDEPTH    = 32;
    localparam int NQ        = 3;
    localparam int CLR_GROUP = 8;
    localparam int CLR_BEATS = NPAGES / CLR_GROUP;
    localparam int CLR_W     = (CLR_BEATS > 1) ? $clog2(CLR_BEATS) : 1;
    localparam int RES_W     = 16;

    localparam int Q_TX  = 0;
    localparam int Q_TXD = 1;
    localparam int Q_RX  = 2;

    typedef logic [PKT_W-1:0] pkt_t;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_ALLOC    = 3'd1,
        OP_RESET    = 3'd2,
        OP_RX_DROP  = 3'd3,
        OP_RX_FREE  = 3'd4,
        OP_FREE_SEL = 3'd5,
        OP_TX_ENQ   = 3'd6,
        OP_TX_FLUSH = 3'd7
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [SIZE_W-1:0] size;
        pkt_t              sel;
    } cmd_s;

    function automatic cmd_s decode_cmd(input logic [7:0] word, input pkt_t sel);
        cmd_s c;
        c.op   = op_e'(word[7:5]);
        c.size = word[SIZE_W-1:0];
        c.sel  = sel;
        return c;
    endfunction

    function automatic logic [RES_W-1:0] grant_word(input pkt_t pkt);
        return {{(RES_W-PKT_W){1'b0}}, pkt};
    endfunction

endpackage

// File: rtl/pbuf_queue.sv
module pbuf_queue #(
    parameter int W     = 6,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         flush,
    input  logic         clr_ovf,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;
    logic          full, pop_ok, push_ok;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign pop_ok  = pop & ~empty;
    assign push_ok = push & (~full | pop_ok);
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_ovf)       ovf <= 1'b0;
        else if (push && !push_ok) ovf <= 1'b1;
    end
endmodule

// File: rtl/pbuf_pagemap.sv
module pbuf_pagemap #(
    parameter int NPAGES = 64,
    parameter int PKT_W  = 6,
    parameter int SIZE_W = 5,
    parameter int GROUP  = 8,
    parameter int GRP_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              alloc_go,
    input  logic              release_go,
    input  logic [PKT_W-1:0]  release_pkt,
    input  logic              clr_go,
    input  logic [GRP_W-1:0]  clr_grp,
    output logic              fit_ok,
    output logic [PKT_W-1:0]  fit_base
);
    localparam int MAX_RUN = 1 << SIZE_W;

    logic [NPAGES-1:0]         used;
    logic [SIZE_W-1:0]         len_tab [NPAGES];
    logic [NPAGES+MAX_RUN-1:0] pad;
    logic [NPAGES-1:0]         alloc_mask, rel_mask, clr_mask;

    // pages past the top count as taken, so a run never wraps
    assign pad = {{MAX_RUN{1'b1}}, used};

    always_comb begin
        logic ok;
        fit_ok   = 1'b0;
        fit_base = '0;
        for (int b = NPAGES - 1; b >= 0; b--) begin
            ok = 1'b1;
            for (int k = 0; k < MAX_RUN; k++) begin
                if (k <= int'(req_size) && pad[b + k]) ok = 1'b0;
            end
            if (ok) begin
                fit_ok   = 1'b1;
                fit_base = PKT_W'(b);
            end
        end
    end

    always_comb begin
        int a_lo, r_lo;
        a_lo = int'(fit_base);
        r_lo = int'(release_pkt);
        for (int i = 0; i < NPAGES; i++) begin
            alloc_mask[i] = alloc_go && i >= a_lo && i <= a_lo + int'(req_size);
            rel_mask[i]   = release_go && i >= r_lo && i <= r_lo + int'(len_tab[release_pkt]);
            clr_mask[i]   = clr_go && (i / GROUP) == int'(clr_grp);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used <= '0;
            for (int i = 0; i < NPAGES; i++) len_tab[i] <= '0;
        end else begin
            used <= (used & ~rel_mask & ~clr_mask) | alloc_mask;
            if (alloc_go) len_tab[fit_base] <= req_size;
        end
    end
endmodule

// File: rtl/pbuf_alloc_unit.sv
module pbuf_alloc_unit
    import pbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [7:0]       cmd_word,
    input  logic [PKT_W-1:0] sel_pkt,
    output logic             busy,
    output logic [RES_W-1:0] alloc_result,
    output logic             alloc_done,
    output logic [15:0]      queue_status,
    output logic [PKT_W-1:0] tx_head,
    output logic             tx_empty,
    input  logic             tx_pop,
    input  logic             txdone_push,
    input  logic [PKT_W-1:0] txdone_pkt,
    input  logic             rx_push,
    input  logic [PKT_W-1:0] rx_pkt,
    output logic [NQ-1:0]    q_overflow
);
    cmd_s              cmd_q;
    logic              cmd_v;
    logic              clr_active;
    logic [CLR_W-1:0]  clr_idx;
    logic              pend;
    logic [SIZE_W-1:0] pend_size;
    logic [RES_W-1:0]  result_q;
    logic              done_q;

    op_e               op;
    logic              fit_ok, alloc_go, defer_go, release_go, is_alloc;
    pkt_t              fit_base, release_pkt;
    logic [SIZE_W-1:0] req_size;

    logic [NQ-1:0]     q_push, q_pop, q_flush, q_clr, q_empty;
    pkt_t              q_din  [NQ];
    pkt_t              q_head [NQ];

    assign busy     = cmd_v | clr_active;
    assign op       = cmd_v ? cmd_q.op : OP_NOP;
    assign is_alloc = (op == OP_ALLOC);
    assign defer_go = pend & ~cmd_v & ~clr_active & fit_ok;
    assign req_size = is_alloc ? cmd_q.size : pend_size;
    assign alloc_go = (is_alloc & fit_ok) | defer_go;

    assign release_go  = ((op == OP_RX_FREE) & ~q_empty[Q_RX]) | (op == OP_FREE_SEL);
    assign release_pkt = (op == OP_RX_FREE) ? q_head[Q_RX] : cmd_q.sel;

    always_comb begin
        q_push         = '0;
        q_pop          = '0;
        q_push[Q_TX]   = (op == OP_TX_ENQ);
        q_push[Q_TXD]  = txdone_push;
        q_push[Q_RX]   = rx_push;
        q_pop[Q_TX]    = tx_pop;
        q_pop[Q_TXD]   = (op == OP_FREE_SEL) && !q_empty[Q_TXD] && (q_head[Q_TXD] == cmd_q.sel);
        q_pop[Q_RX]    = (op == OP_RX_DROP) || (op == OP_RX_FREE);
        q_flush[Q_TX]  = (op == OP_TX_FLUSH) || (op == OP_RESET);
        q_flush[Q_TXD] = (op == OP_TX_FLUSH) || (op == OP_RESET);
        q_flush[Q_RX]  = (op == OP_RESET);
        q_clr          = {NQ{op == OP_RESET}};
        q_din[Q_TX]    = cmd_q.sel;
        q_din[Q_TXD]   = txdone_pkt;
        q_din[Q_RX]    = rx_pkt;
    end

    generate
        for (genvar gi = 0; gi < NQ; gi++) begin : g_q
            pbuf_queue #(.W(PKT_W), .DEPTH(QDEPTH)) u_q (
                .clk    (clk),
                .rst    (rst),
                .push   (q_push[gi]),
                .din    (q_din[gi]),
                .pop    (q_pop[gi]),
                .flush  (q_flush[gi]),
                .clr_ovf(q_clr[gi]),
                .head   (q_head[gi]),
                .empty  (q_empty[gi]),
                .ovf    (q_overflow[gi])
            );
        end
    endgenerate

    pbuf_pagemap #(
        .NPAGES(NPAGES), .PKT_W(PKT_W), .SIZE_W(SIZE_W),
        .GROUP(CLR_GROUP), .GRP_W(CLR_W)
    ) u_map (
        .clk        (clk),
        .rst        (rst),
        .req_size   (req_size),
        .alloc_go   (alloc_go),
        .release_go (release_go),
        .release_pkt(release_pkt),
        .clr_go     (clr_active),
        .clr_grp    (clr_idx),
        .fit_ok     (fit_ok),
        .fit_base   (fit_base)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_v      <= 1'b0;
            cmd_q      <= '0;
            clr_active <= 1'b0;
            clr_idx    <= '0;
            pend       <= 1'b0;
            pend_size  <= '0;
            result_q   <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            cmd_v  <= cmd_wr & ~busy;
            if (cmd_wr && !busy) cmd_q <= decode_cmd(cmd_word, sel_pkt);

            if (clr_active) begin
                clr_idx <= clr_idx + 1'b1;
                if (clr_idx == CLR_W'(CLR_BEATS - 1)) clr_active <= 1'b0;
            end

            if (is_alloc) begin
                if (fit_ok) begin
                    result_q <= grant_word(fit_base);
                    pend     <= 1'b0;
                end else begin
                    result_q  <= {1'b1, {(RES_W-1){1'b0}}};
                    pend      <= 1'b1;
                    pend_size <= cmd_q.size;
                end
            end else if (op == OP_RESET) begin
                clr_active <= 1'b1;
                clr_idx    <= '0;
                pend       <= 1'b0;
                result_q   <= '0;
            end else if (defer_go) begin
                result_q <= grant_word(fit_base);
                pend     <= 1'b0;
                done_q   <= 1'b1;
            end
        end
    end

    assign alloc_result = result_q;
    assign alloc_done   = done_q;
    assign tx_head      = q_head[Q_TX];
    assign tx_empty     = q_empty[Q_TX];
    assign queue_status = {q_empty[Q_RX], 1'b0, q_head[Q_RX],
                           q_empty[Q_TXD], 1'b0, q_head[Q_TXD]};
endmodule

// File: rtl/pbuf_alloc_unit_chk.sv
module pbuf_alloc_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_wr,
    input logic        busy,
    input logic [15:0] alloc_result,
    input logic        alloc_done,
    input logic [15:0] queue_status,
    input logic        rx_push,
    input logic [2:0]  q_overflow
);
    a_r4_busy_after_write: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy) |=> busy);

    a_r2_grant_format: assert property (@(posedge clk) disable iff (rst)
        !alloc_result[15] |-> (alloc_result[14:6] == '0));

    a_r3_fail_format: assert property (@(posedge clk) disable iff (rst)
        alloc_result[15] |-> (alloc_result[14:0] == '0));

    a_r3_done_is_grant: assert property (@(posedge clk) disable iff (rst)
        alloc_done |-> !alloc_result[15]);

    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        alloc_done |=> !alloc_done);

    a_r7_rx_empty_head: assert property (@(posedge clk) disable iff (rst)
        queue_status[15] |-> (queue_status[14:8] == '0));

    a_r7_txd_empty_head: assert property (@(posedge clk) disable iff (rst)
        queue_status[7] |-> (queue_status[6:0] == '0));

    a_r11_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ((q_overflow & $past(q_overflow)) == $past(q_overflow)));

    a_r12_push_lands: assert property (@(posedge clk) disable iff (rst)
        (rx_push && !busy) |=> !queue_status[15]);
endmodule

bind pbuf_alloc_unit pbuf_alloc_unit_chk u_chk (.*);

// File: tb/pbuf_alloc_unit_test.sv
`timescale 1ns/1ps
module pbuf_alloc_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_word = '0;
    logic [5:0]  sel_pkt = '0;
    logic        busy;
    logic [15:0] alloc_result;
    logic        alloc_done;
    logic [15:0] queue_status;
    logic [5:0]  tx_head;
    logic        tx_empty;
    logic        tx_pop = 1'b0;
    logic        txdone_push = 1'b0;
    logic [5:0]  txdone_pkt = '0;
    logic        rx_push = 1'b0;
    logic [5:0]  rx_pkt = '0;
    logic [2:0]  q_overflow;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pbuf_alloc_unit uut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_word(cmd_word), .sel_pkt(sel_pkt),
        .busy(busy), .alloc_result(alloc_result), .alloc_done(alloc_done),
        .queue_status(queue_status), .tx_head(tx_head), .tx_empty(tx_empty),
        .tx_pop(tx_pop), .txdone_push(txdone_push), .txdone_pkt(txdone_pkt),
        .rx_push(rx_push), .rx_pkt(rx_pkt), .q_overflow(q_overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // issue one command at a falling edge, wait until busy drops
    task automatic do_cmd(input logic [2:0] op, input logic [4:0] sz, input logic [5:0] sel,
                          output int nbusy);
        cmd_word = {op, sz};
        sel_pkt  = sel;
        cmd_wr   = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        nbusy  = 0;
        while (busy) begin
            nbusy++;
            @(negedge clk);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [4:0] sz, input logic [5:0] sel);
        int nb;
        do_cmd(op, sz, sel, nb);
    endtask

    task automatic push_rx(input logic [5:0] p);
        rx_pkt  = p;
        rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic t_reset_state;
        chk("R1 busy", busy, 0);
        chk("R1 result", alloc_result, 16'h0000);
        chk("R1 status", queue_status, 16'h8080);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 overflow", q_overflow, 0);
        cmd(3'd1, 5'd31, 6'd0);
        cmd(3'd1, 5'd31, 6'd0);
        chk("R1 all pages free, second half", alloc_result, 16'h0020);
    endtask

    task automatic t_soft_reset;
        int nb;
        push_rx(6'd3);
        do_cmd(3'd6, 5'd0, 6'd4, nb);
        do_cmd(3'd2, 5'd0, 6'd0, nb);
        chk("R5 busy cycles", nb, 9);
        chk("R5 status", queue_status, 16'h8080);
        chk("R5 tx_empty", tx_empty, 1);
        chk("R5 result", alloc_result, 16'h0000);
        cmd(3'd1, 5'd31, 6'd0);
        cmd(3'd1, 5'd31, 6'd0);
        chk("R5 pages freed", alloc_result, 16'h0020);
        cmd(3'd2, 5'd0, 6'd0);
    endtask

    task automatic t_alloc;
        cmd(3'd1, 5'd0, 6'd0);
        chk("R2 first single page", alloc_result, 16'h0000);
        cmd(3'd1, 5'd2, 6'd0);
        chk("R2 three pages", alloc_result, 16'h0001);
        cmd(3'd1, 5'd0, 6'd0);
        chk("R2 next single", alloc_result, 16'h0004);
        cmd(3'd5, 5'd0, 6'd1);
        cmd(3'd1, 5'd1, 6'd0);
        chk("R9 R2 reuse freed run", alloc_result, 16'h0001);
        cmd(3'd1, 5'd2, 6'd0);
        chk("R2 skip short gap", alloc_result, 16'h0005);
        cmd(3'd1, 5'd0, 6'd0);
        chk("R2 gap page 3", alloc_result, 16'h0003);
        cmd(3'd2, 5'd0, 6'd0);
    endtask

    task automatic t_busy_ignore;
        cmd_word = {3'd1, 5'd0};
        cmd_wr   = 1'b1;
        @(negedge clk);
        chk("R4 busy after write", busy, 1);
        cmd_word = {3'd6, 5'd0};
        sel_pkt  = 6'd9;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk("R4 busy falls", busy, 0);
        @(negedge clk);
        chk("R4 write while busy dropped", tx_empty, 1);
        cmd(3'd2, 5'd0, 6'd0);
    endtask

    task automatic t_deferred;
        cmd(3'd1, 5'd31, 6'd0);
        cmd(3'd1, 5'd31, 6'd0);
        cmd(3'd1, 5'd0, 6'd0);
        chk("R3 fail word", alloc_result, 16'h8000);
        chk("R3 no done on fail", alloc_done, 0);
        cmd(3'd5, 5'd0, 6'd32);
        chk("R3 done not yet", alloc_done, 0);
        @(negedge clk);
        chk("R3 done pulse", alloc_done, 1);
        chk("R3 deferred grant", alloc_result, 16'h0020);
        @(negedge clk);
        chk("R3 done one cycle", alloc_done, 0);
        cmd(3'd2, 5'd0, 6'd0);
    endtask

    task automatic t_txq;
        cmd(3'd6, 5'd0, 6'd5);
        cmd(3'd6, 5'd0, 6'd6);
        cmd(3'd6, 5'd0, 6'd7);
        chk("R6 head", tx_head, 6'd5);
        chk("R6 not empty", tx_empty, 0);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
        chk("R6 pop advances", tx_head, 6'd6);
        txdone_pkt  = 6'd33;
        txdone_push = 1'b1;
        @(negedge clk);
        txdone_push = 1'b0;
        chk("R7 completion head", queue_status, 16'h8021);
        cmd(3'd5, 5'd0, 6'd33);
        chk("R9 matching release pops completion", queue_status, 16'h8080);
        txdone_pkt  = 6'd12;
        txdone_push = 1'b1;
        @(negedge clk);
        txdone_push = 1'b0;
        push_rx(6'd17);
        cmd(3'd7, 5'd0, 6'd0);
        chk("R10 tx flushed", tx_empty, 1);
        chk("R10 rx kept, completion flushed", queue_status, 16'h1180);
        cmd(3'd2, 5'd0, 6'd0);
    endtask

    task automatic t_rx;
        cmd(3'd1, 5'd19, 6'd0);
        cmd(3'd1, 5'd0, 6'd0);
        chk("R8 setup pkt", alloc_result, 16'h0014);
        push_rx(6'd0);
        push_rx(6'd20);
        chk("R7 rx head", queue_status, 16'h0080);
        cmd(3'd3, 5'd0, 6'd0);
        chk("R8 drop advances", queue_status, 16'h1480);
        cmd(3'd4, 5'd0, 6'd0);
        chk("R8 free empties", queue_status, 16'h8080);
        cmd(3'd1, 5'd0, 6'd0);
        chk("R8 only rx-free released pages", alloc_result, 16'h0014);
        cmd(3'd2, 5'd0, 6'd0);
    endtask

    task automatic t_overflow;
        for (int i = 0; i < 33; i++) begin
            rx_pkt  = 6'(i);
            rx_push = 1'b1;
            @(negedge clk);
        end
        rx_push = 1'b0;
        chk("R11 rx overflow flag", q_overflow, 3'b100);
        for (int i = 0; i < 32; i++) begin
            if (i == 0 || i == 31) chk("R11 order kept", queue_status[13:8], 6'(i));
            cmd(3'd3, 5'd0, 6'd0);
        end
        chk("R11 33rd dropped", queue_status[15], 1);
        chk("R11 flag sticky", q_overflow, 3'b100);
        cmd(3'd2, 5'd0, 6'd0);
        chk("R11 cleared by reset cmd", q_overflow, 3'b000);
    endtask

    task automatic t_same_cycle;
        push_rx(6'd7);
        cmd_word = {3'd3, 5'd0};
        cmd_wr   = 1'b1;
        @(negedge clk);
        cmd_wr  = 1'b0;
        rx_pkt  = 6'd9;
        rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
        chk("R12 push and drop together", queue_status, 16'h0980);
        cmd(3'd3, 5'd0, 6'd0);
        chk("R12 single entry left", queue_status[15], 1);
        cmd_word = {3'd3, 5'd0};
        cmd_wr   = 1'b1;
        @(negedge clk);
        cmd_wr  = 1'b0;
        rx_pkt  = 6'd11;
        rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
        chk("R12 drop on empty ignored", queue_status, 16'h0B80);
        cmd(3'd2, 5'd0, 6'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_soft_reset();
        t_alloc();
        t_busy_ignore();
        t_deferred();
        t_txq();
        t_rx();
        t_overflow();
        t_same_cycle();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule